// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 16-bit virtual address into a physical address of 18 or 22 bits. The top three bits of the virtual address pick one of eight segments. A per-segment base register, counted in 64-byte clicks, is added to the 13-bit offset. Descriptor storage is split into six banks: one instruction bank and one data bank for each of the kernel, supervisor and user modes. Each segment holds a base word and a descriptor word. The descriptor word carries a length field, a direction bit and an access-control code.

Software reaches every descriptor word, every base word and two control words through a register port. The register port has a one-cycle read latency. The translation port takes a mode, a data/instruction selector and a virtual address. Two cycles later it returns the physical address, a flag that marks the top 8 KB of the active address space, and a non-resident abort. Length checks, write protection, traps and bus timing are handled elsewhere.

Top module: `seg_xlate`

Register map (`reg_addr`):
- When bit 7 is 0, the address selects a descriptor file word. Bit 6 = 1 selects a base word and bit 6 = 0 selects a descriptor word. Bits 5:4 hold the mode code, bit 3 the space (0 = instruction, 1 = data) and bits 2:0 the segment.
- When bit 7 is 1, the address selects a control word: `8'h80` is the main control and `8'h81` is the extended control.

## Requirements
- R1: Any base word written through the register port reads back as all 16 bits unchanged. The read data appears one cycle after `reg_addr` is presented.
- R2: A descriptor word keeps only bits 14:8 (length), bit 3 (direction) and bits 2:0 (access code). Bits 15 and 7:4 always read as zero.
- R3: The main control word has its enable in bit 0. The extended control word has the data-space enables in bit 0 (kernel), bit 1 (supervisor) and bit 2 (user), and the 22-bit enable in bit 4. Every other bit reads as zero. Reset clears both words.
- R4: While the enable is 0, the physical address equals the zero-extended virtual address. The I/O flag is set for virtual addresses from 16'hE000 upward, and no abort is raised.
- R5: While the enable is 1, virtual bits 15:13 pick the segment. In 22-bit mode the physical address is base*64 + va[12:0], taken modulo 2^22.
- R6: In 18-bit mode the sum is cut to 18 bits, so base bits 15:12 have no effect on the address. Those bits are still stored and read back.
- R7: A data reference (`tr_dspace`=1) uses the data bank of its mode only when that mode's data-space enable is set. Otherwise it uses the instruction bank. An instruction reference always uses the instruction bank.
- R8: With translation on, the I/O flag is set when physical bits 21:13 (22-bit mode) or 17:13 (18-bit mode) are all ones. So a base of 16'hFF80 reaches the I/O page in both modes, and a base of 16'h0F80 reaches it only in 18-bit mode.
- R9: The abort is raised exactly when translation is on and the selected segment has access code 0. Any nonzero code gives no abort.
- R10: Mode code 0 is kernel and code 1 is supervisor. Codes 2 and 3 both select the user banks, for register access and for translation alike.
- R11: A translation result appears on the outputs two cycles after its request. The control state in effect is the state at the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (map above) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after address |
| tr_mode | input | 2 | Processor mode code of the reference |
| tr_dspace | input | 1 | 1 = data reference, 0 = instruction reference |
| tr_va | input | 16 | Virtual address |
| tr_pa | output | 22 | Physical address |
| tr_io | output | 1 | Physical address lies in the I/O page |
| tr_abort | output | 1 | Non-resident abort |

## Verification
The bench builds the default configuration: 16-bit virtual addresses, eight segments, 64-byte clicks and 22-bit physical addresses. With these values the whole descriptor file (48 descriptor and 48 base words) can be written and read back in full. The bench then translates every mode code, both spaces and every segment, at offsets at the segment start, the segment end and the middle. It repeats this sweep under eight combinations of enable, 22-bit mode and data-space enables. Base patterns with high nibbles set, together with dedicated I/O-page bases, exercise the 18-bit truncation and both I/O-page boundaries.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    MODE_KER = 2'd0,
    MODE_SUP = 2'd1,
    MODE_RSV = 2'd2,
    MODE_USR = 2'd3
  } mode_e;

  localparam int BANK_W  = 2;
  localparam int ACF_W   = 3;
  localparam logic [15:0] DESC_KEEP = 16'h7F0F;

  // kernel -> 0, supervisor -> 1, reserved and user -> 2
  function automatic logic [BANK_W-1:0] bank_of(input logic [1:0] m);
    if (m == MODE_KER)      return 2'd0;
    else if (m == MODE_SUP) return 2'd1;
    else                    return 2'd2;
  endfunction
endpackage

// File: rtl/seg_desc_ram.sv
module seg_desc_ram #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  qa,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  qb
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[raddr_a];
    qb <= mem[raddr_b];
  end
endmodule

// File: rtl/seg_ctl_regs.sv
module seg_ctl_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel_ext,
  input  logic [DW-1:0] wdata,
  output logic          en,
  output logic          x22,
  output logic [2:0]    den,
  output logic [DW-1:0] rd_main,
  output logic [DW-1:0] rd_ext
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      x22 <= 1'b0;
      den <= 3'b000;
    end else if (we) begin
      if (!sel_ext) en <= wdata[0];
      else begin
        den <= wdata[2:0];
        x22 <= wdata[4];
      end
    end
  end

  logic unused_wd;
  assign unused_wd = ^{wdata[DW-1:5], wdata[3]};

  assign rd_main = DW'(en);
  assign rd_ext  = DW'({x22, 1'b0, den});
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W     = 16,
  parameter int SEG_W    = 3,
  parameter int DW       = 16,
  parameter int CLICK_SH = 6,
  parameter int PA_W     = 22,
  parameter int PA_S_W   = 18,
  parameter int RA_W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [1:0]      tr_mode,
  input  logic            tr_dspace,
  input  logic [VA_W-1:0] tr_va,
  output logic [PA_W-1:0] tr_pa,
  output logic            tr_io,
  output logic            tr_abort
);
  localparam int OFF_W = VA_W - SEG_W;
  localparam int IO_SH = OFF_W;
  localparam int IX_W  = BANK_W + 1 + SEG_W;

  // control registers
  logic          ctl_en, ctl_x22;
  logic [2:0]    ctl_den;
  logic [DW-1:0] ctl_main, ctl_ext;
  logic          ctl_we, par_we, pdr_we;

  assign ctl_we = reg_we &  reg_addr[RA_W-1];
  assign par_we = reg_we & ~reg_addr[RA_W-1] &  reg_addr[RA_W-2];
  assign pdr_we = reg_we & ~reg_addr[RA_W-1] & ~reg_addr[RA_W-2];

  seg_ctl_regs #(.DW(DW)) ctl_i (
    .clk(clk), .rst(rst), .we(ctl_we), .sel_ext(reg_addr[0]),
    .wdata(reg_wdata), .en(ctl_en), .x22(ctl_x22), .den(ctl_den),
    .rd_main(ctl_main), .rd_ext(ctl_ext)
  );

  // register-port index: {bank, space, segment}
  logic [IX_W-1:0] r_idx;
  assign r_idx = {bank_of(reg_addr[5:4]), reg_addr[3], reg_addr[SEG_W-1:0]};

  // translation index, space chosen by per-mode data enable
  logic [BANK_W-1:0] t_bank;
  logic              t_dsel;
  logic [IX_W-1:0]   t_idx;
  assign t_bank = bank_of(tr_mode);
  assign t_dsel = tr_dspace & ctl_den[t_bank];
  assign t_idx  = {t_bank, t_dsel, tr_va[VA_W-1 -: SEG_W]};

  logic [DW-1:0] par_t, par_r, pdr_t, pdr_r;

  seg_desc_ram #(.W(DW), .AW(IX_W)) par_ram_i (
    .clk(clk), .we(par_we), .waddr(r_idx), .wdata(reg_wdata),
    .raddr_a(t_idx), .qa(par_t), .raddr_b(r_idx), .qb(par_r)
  );

  seg_desc_ram #(.W(DW), .AW(IX_W)) pdr_ram_i (
    .clk(clk), .we(pdr_we), .waddr(r_idx), .wdata(reg_wdata & DW'(DESC_KEEP)),
    .raddr_a(t_idx), .qa(pdr_t), .raddr_b(r_idx), .qb(pdr_r)
  );

  logic unused_pdr_hi;
  assign unused_pdr_hi = ^pdr_t[DW-1:ACF_W];

  // register read path
  logic [1:0]    r_sel;
  logic [DW-1:0] ctl_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      r_sel <= 2'b00;
      ctl_q <= '0;
    end else begin
      r_sel <= reg_addr[RA_W-1 -: 2];
      ctl_q <= reg_addr[0] ? ctl_ext : ctl_main;
    end
  end

  always_comb begin
    if (r_sel[1])      reg_rdata = ctl_q;
    else if (r_sel[0]) reg_rdata = par_r;
    else               reg_rdata = pdr_r;
  end

  // stage 1: request parameters alongside the memory read
  logic [VA_W-1:0] s1_va;
  logic            s1_en, s1_x22;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_va  <= '0;
      s1_en  <= 1'b0;
      s1_x22 <= 1'b0;
    end else begin
      s1_va  <= tr_va;
      s1_en  <= ctl_en;
      s1_x22 <= ctl_x22;
    end
  end

  // stage 2: relocation and flags
  logic [PA_W-1:0] sum, pa_n;
  logic            io_n, ab_n;
  assign sum = (PA_W'(par_t) << CLICK_SH) + PA_W'(s1_va[OFF_W-1:0]);

  always_comb begin
    if (!s1_en) begin
      pa_n = PA_W'(s1_va);
      io_n = &s1_va[VA_W-1:IO_SH];
    end else if (s1_x22) begin
      pa_n = sum;
      io_n = &sum[PA_W-1:IO_SH];
    end else begin
      pa_n = PA_W'(sum[PA_S_W-1:0]);
      io_n = &sum[PA_S_W-1:IO_SH];
    end
    ab_n = s1_en && (pdr_t[ACF_W-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_pa    <= '0;
      tr_io    <= 1'b0;
      tr_abort <= 1'b0;
    end else begin
      tr_pa    <= pa_n;
      tr_io    <= io_n;
      tr_abort <= ab_n;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int DW     = 16,
  parameter int PA_W   = 22,
  parameter int PA_S_W = 18,
  parameter int VA_W   = 16,
  parameter int IO_SH  = 13,
  parameter int RA_W   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [RA_W-1:0] reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic [PA_W-1:0] tr_pa,
  input logic            tr_io,
  input logic            tr_abort,
  input logic            s1_en,
  input logic            s1_x22,
  input logic            ctl_en
);
  p_desc_mask_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr[RA_W-1 -: 2]) == 2'b00) |-> ((reg_rdata & DW'(16'h80F0)) == '0));

  p_ext_bits_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == RA_W'(8'h81)) |-> ((reg_rdata & ~DW'(16'h0017)) == '0));

  p_rst_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ctl_en);

  p_off_ident_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(s1_en) |-> ((tr_pa[PA_W-1:VA_W] == '0) && !tr_abort));

  p_short_pa_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(s1_x22) |-> (tr_pa[PA_W-1:PA_S_W] == '0));

  p_io_top_r8: assert property (@(posedge clk) disable iff (rst)
    tr_io |-> (&tr_pa[IO_SH+2:IO_SH]));

  p_abort_en_r9: assert property (@(posedge clk) disable iff (rst)
    tr_abort |-> $past(s1_en));
endmodule

bind seg_xlate seg_xlate_chk #(
  .DW(DW), .PA_W(PA_W), .PA_S_W(PA_S_W), .VA_W(VA_W), .IO_SH(VA_W - SEG_W), .RA_W(RA_W)
) chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .tr_pa(tr_pa), .tr_io(tr_io), .tr_abort(tr_abort),
  .s1_en(s1_en), .s1_x22(s1_x22), .ctl_en(ctl_en)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [1:0]  tr_mode = 2'd0;
  logic        tr_dspace = 1'b0;
  logic [15:0] tr_va = 16'h0;
  logic [21:0] tr_pa;
  logic        tr_io, tr_abort;

  always #4 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tr_mode(tr_mode),
    .tr_dspace(tr_dspace), .tr_va(tr_va), .tr_pa(tr_pa), .tr_io(tr_io),
    .tr_abort(tr_abort)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_pdr [64];
  logic [15:0] m_par [64];
  bit          b_en, b_x22;
  logic [2:0]  b_den;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bank(input logic [1:0] m);
    return (m == 2'd0) ? 0 : (m == 2'd1) ? 1 : 2;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata === exp, req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic set_ctl(input bit en, input bit x22, input logic [2:0] den);
    wr(8'h80, {15'b0, en});
    wr(8'h81, {11'b0, x22, 1'b0, den});
    b_en = en; b_x22 = x22; b_den = den;
  endtask

  // descriptor or base write that also updates the bench copy
  task automatic wr_desc(input bit is_par, input logic [1:0] m, input bit sp,
                         input logic [2:0] seg, input logic [15:0] d);
    int ix;
    ix = bank(m) * 16 + int'(sp) * 8 + int'(seg);
    wr({1'b0, is_par, m, sp, seg}, d);
    if (is_par) m_par[ix] = d;
    else        m_pdr[ix] = d & 16'h7F0F;
  endtask

  task automatic xl(input logic [1:0] m, input bit sp, input logic [15:0] va);
    int ix, b;
    bit dsel;
    logic [21:0] sum, epa;
    bit eio, eab;
    string tg;
    @(negedge clk);
    tr_mode = m; tr_dspace = sp; tr_va = va;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    b    = bank(m);
    dsel = sp & b_den[b];
    ix   = b * 16 + int'(dsel) * 8 + int'(va[15:13]);
    sum  = ({6'b0, m_par[ix]} << 6) + {9'b0, va[12:0]};
    if (!b_en) begin
      epa = {6'b0, va}; eio = (va >= 16'hE000); eab = 1'b0; tg = "R4";
    end else if (b_x22) begin
      epa = sum; eio = &sum[21:13]; eab = (m_pdr[ix][2:0] == 3'd0); tg = "R5";
    end else begin
      epa = {4'b0, sum[17:0]}; eio = &sum[17:13]; eab = (m_pdr[ix][2:0] == 3'd0); tg = "R6";
    end
    if (sp && b_en) tg = {tg, " R7"};
    if (m == 2'd2 && b_en) tg = {tg, " R10"};
    chk(tr_pa === epa, {tg, " pa R11"}, 32'(tr_pa), 32'(epa));
    chk(tr_io === eio, {tg, " R8 io"}, 32'(tr_io), 32'(eio));
    chk(tr_abort === eab, {tg, " R9 abort"}, 32'(tr_abort), 32'(eab));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    b_en = 0; b_x22 = 0; b_den = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R3: reset state of both control words
    rd_chk(8'h80, 16'h0000, "R3 main after reset");
    rd_chk(8'h81, 16'h0000, "R3 ext after reset");
    wr(8'h80, 16'hFFFF);
    wr(8'h81, 16'hFFFF);
    rd_chk(8'h80, 16'h0001, "R3 main writable bits");
    rd_chk(8'h81, 16'h0017, "R3 ext writable bits");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd_chk(8'h80, 16'h0000, "R3 main cleared by reset");
    rd_chk(8'h81, 16'h0000, "R3 ext cleared by reset");

    // fill all six banks through mode codes 0, 1, 3
    for (int mi = 0; mi < 3; mi++)
      for (int sp = 0; sp < 2; sp++)
        for (int sg = 0; sg < 8; sg++) begin
          int ix;
          logic [1:0] m;
          m  = (mi == 2) ? 2'd3 : 2'(mi);
          ix = mi * 16 + sp * 8 + sg;
          wr_desc(1'b0, m, sp[0], sg[2:0], 16'hFFFF ^ 16'(ix * 16'h0135));
          wr_desc(1'b1, m, sp[0], sg[2:0], 16'(ix * 16'h0A3B + 16'h1C05));
        end

    // R1, R2: full read-back
    for (int mi = 0; mi < 3; mi++)
      for (int sp = 0; sp < 2; sp++)
        for (int sg = 0; sg < 8; sg++) begin
          int ix;
          logic [1:0] m;
          m  = (mi == 2) ? 2'd3 : 2'(mi);
          ix = mi * 16 + sp * 8 + sg;
          rd_chk({2'b00, m, sp[0], sg[2:0]}, m_pdr[ix], "R2 descriptor read-back");
          rd_chk({2'b01, m, sp[0], sg[2:0]}, m_par[ix], "R1 base read-back");
        end

    // R10: mode code 2 reaches the user bank
    wr_desc(1'b1, 2'd2, 1'b1, 3'd5, 16'h3C21);
    rd_chk({2'b01, 2'd3, 1'b1, 3'd5}, 16'h3C21, "R10 alias write seen as user");
    wr_desc(1'b0, 2'd3, 1'b0, 3'd2, 16'hFFFF);
    rd_chk({2'b00, 2'd2, 1'b0, 3'd2}, 16'h7F0F, "R10 R2 alias read of user");

    // translation sweep under several control settings
    for (int cfg = 0; cfg < 8; cfg++) begin
      set_ctl(cfg != 2, cfg[0], 3'(cfg * 3));
      for (int m = 0; m < 4; m++)
        for (int sp = 0; sp < 2; sp++)
          for (int sg = 0; sg < 8; sg++) begin
            xl(2'(m), sp[0], {sg[2:0], 13'h0000});
            xl(2'(m), sp[0], {sg[2:0], 13'h1FFF});
            xl(2'(m), sp[0], {sg[2:0], 13'h0A55});
          end
    end

    // R8, R6: I/O page reach in both widths
    wr_desc(1'b0, 2'd0, 1'b0, 3'd7, 16'h7F06);
    wr_desc(1'b1, 2'd0, 1'b0, 3'd7, 16'hFF80);
    set_ctl(1'b1, 1'b1, 3'b000);
    xl(2'd0, 1'b0, 16'hE000);
    xl(2'd0, 1'b0, 16'hFFFE);
    set_ctl(1'b1, 1'b0, 3'b000);
    xl(2'd0, 1'b0, 16'hE010);
    wr_desc(1'b1, 2'd0, 1'b0, 3'd7, 16'h0F80);
    xl(2'd0, 1'b0, 16'hE000);
    set_ctl(1'b1, 1'b1, 3'b000);
    xl(2'd0, 1'b0, 16'hE000);
    rd_chk(8'h47, 16'h0F80, "R6 base top bits kept");

    // R11: control state sampled at request cycle
    @(negedge clk);
    tr_mode = 2'd0; tr_dspace = 1'b0; tr_va = 16'hE004;
    reg_we = 1'b1; reg_addr = 8'h80; reg_wdata = 16'h0000;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    chk(tr_pa === 22'h03E004, "R11 pa uses request-cycle control",
        32'(tr_pa), 32'h03E004);

    summary();
    $finish;
  end
endmodule